// File: doc/BRIEF.md
# ADC Serial Command Port

This block is the slave end of a four-wire serial register port inside a multi-channel converter controller. The master holds chip select low and clocks bytes in on the serial data input. Each transaction opens with one 8-bit command byte. That byte alone names the target register and says whether the master writes it or reads it. The payload that follows moves most-significant bit first. The block stores the following registers:

- a 24-bit offset word for each physical channel;
- a 24-bit gain word for each physical channel;
- one 24-bit configuration word;
- a chain of 12-bit channel setups, packed two to a 24-bit word.

The port samples SCLK, chip select and SDI on the system clock. These inputs must already be synchronous to that clock, and each SCLK level must last at least two clock cycles. The master sets the pace of every transfer. The port has no back-pressure: it accepts or presents one bit per SCLK period and never stalls. A two-byte resynchronisation pattern recovers byte framing from any point in the stream. Raising chip select abandons whatever is in progress.

Top module: `adc_cmd_port`

## Requirements
- R1: A command byte is received MSB first, with SDI sampled on rising SCLK edges. Its fields are:
  - bit 7 must be 0 for a register command;
  - bits 6:4 hold the channel number;
  - bit 3 selects the direction, 1 for read and 0 for write;
  - bits 2:0 select the register: 001 offset, 010 gain, 011 configuration, 101 channel-setup chain.
- R2: After reset the registers hold these values:
  - every offset word is 0x000000;
  - every gain word is 0x400000;
  - the configuration word is 0x000000;
  - every setup is 0x000.
- R3: For a read, the first payload bit appears on SDO after the falling SCLK edge that follows the eighth rising edge. One further bit appears per falling edge, MSB first. Offset, gain and configuration reads carry 24 bits.
- R4: The port ignores a command byte in either of these cases:
  - its select code is 000, 100, 110 or 111;
  - its bit 7 is 1 (for example 0xFF or 0xFE alone).

  The all-zero null byte is one such case. An ignored byte changes no register, and the next 8 bits form a new command byte.
- R5: The channel field picks which offset or gain word is accessed. An offset or gain command whose channel is NUM_CH or higher (4 to 7 by default) is ignored as in R4. Configuration and setup commands disregard the channel field.
- R6: While chip select is high, the SDO output enable is 0 and SDO is 0. While chip select is low, the output enable is 1.
- R7: If chip select rises before a transfer completes, the transfer is abandoned and the target register keeps its old value. The next selection starts with a command byte.
- R8: A setup-chain access moves NUM_SETUP x 12 bits (96 by default). Setup 0 occupies the first 12 bits sent, and the last setup occupies the final 12 bits. A write updates the chain only once every bit has arrived.
- R9: The resynchronisation pattern is 0xFF followed by 0xFE on SDI, that is, sixteen consecutive bits at any bit alignment and in any phase.
  - The pattern returns the port to waiting for a command byte.
  - A write still in progress when the pattern completes is discarded.
- R10: A completed write takes effect at the rising edge that carries its final bit. A later read of the same register returns the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select, synchronous to clk |
| sclk | input | 1 | Serial clock, synchronous to clk |
| sdi | input | 1 | Serial data from master |
| sdo | output | 1 | Serial data to master |
| sdo_oe | output | 1 | Output enable for the SDO pad driver |

## Verification
The bench builds the port with its defaults: four channels, 24-bit words and eight 12-bit setups. The chain is therefore four words long, and a partial abort after three words (72 bits) can be told apart from a full commit. Four channels behind a 3-bit channel field leave codes 4 to 7 outside the stored range, so the channel-rejection path is reachable. Reads are queued as expected words on a scoreboard and compared bit-assembled at SDO. Resynchronisation is exercised both inside a write payload and at a misaligned point of the command phase.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

  typedef enum logic [2:0] {
    SEL_NONE   = 3'b000,
    SEL_OFFSET = 3'b001,
    SEL_GAIN   = 3'b010,
    SEL_CONFIG = 3'b011,
    SEL_SETUP  = 3'b101
  } reg_sel_e;

  typedef enum logic [1:0] {
    PH_CMD = 2'd0,
    PH_WR  = 2'd1,
    PH_RD  = 2'd2
  } phase_e;

  typedef struct packed {
    logic       conv;   // must be 0 for register access
    logic [2:0] chan;
    logic       rd;
    logic [2:0] sel;
  } cmd_t;

  localparam int CHAN_FIELD_W = 3;
  localparam logic [15:0] RESYNC_PAIR = 16'hFFFE;

endpackage

// File: rtl/adc_port_edge.sv
module adc_port_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  output logic rise,
  output logic fall
);
  logic sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  assign rise = sclk & ~sclk_q;
  assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/adc_port_regs.sv
module adc_port_regs
  import adc_port_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int WORD_W     = 24,
  parameter int SETUP_BITS = 96,
  parameter logic [WORD_W-1:0] GAIN_RST = 24'h400000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [2:0]              wr_sel,
  input  logic [CHAN_FIELD_W-1:0] wr_ch,
  input  logic [SETUP_BITS-1:0]   wr_data,
  input  logic [2:0]              rd_sel,
  input  logic [CHAN_FIELD_W-1:0] rd_ch,
  output logic [SETUP_BITS-1:0]   rd_data
);
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int PAD_W = SETUP_BITS - WORD_W;

  logic [NUM_CH*WORD_W-1:0] off_flat, gain_flat;
  logic [WORD_W-1:0]        cfg_q;
  logic [SETUP_BITS-1:0]    setup_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [WORD_W-1:0] off_r, gain_r;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        off_r  <= '0;
        gain_r <= GAIN_RST;
      end else if (wr_en && wr_ch == CHAN_FIELD_W'(c)) begin
        if (wr_sel == SEL_OFFSET) off_r  <= wr_data[WORD_W-1:0];
        if (wr_sel == SEL_GAIN)   gain_r <= wr_data[WORD_W-1:0];
      end
    end
    assign off_flat[c*WORD_W +: WORD_W]  = off_r;
    assign gain_flat[c*WORD_W +: WORD_W] = gain_r;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      setup_q <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_CONFIG) cfg_q   <= wr_data[WORD_W-1:0];
      if (wr_sel == SEL_SETUP)  setup_q <= wr_data;
    end
  end

  logic [CH_W-1:0] rd_idx;
  assign rd_idx = rd_ch[CH_W-1:0];

  always_comb begin
    unique case (rd_sel)
      SEL_OFFSET: rd_data = {off_flat[rd_idx*WORD_W +: WORD_W], {PAD_W{1'b0}}};
      SEL_GAIN:   rd_data = {gain_flat[rd_idx*WORD_W +: WORD_W], {PAD_W{1'b0}}};
      SEL_CONFIG: rd_data = {cfg_q, {PAD_W{1'b0}}};
      SEL_SETUP:  rd_data = setup_q;
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/adc_port_ctrl.sv
module adc_port_ctrl
  import adc_port_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int WORD_W     = 24,
  parameter int SETUP_BITS = 96,
  parameter int CNT_W      = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    rise,
  input  logic                    fall,
  input  logic                    sdi,
  output logic                    wr_en,
  output logic [2:0]              wr_sel,
  output logic [CHAN_FIELD_W-1:0] wr_ch,
  output logic [SETUP_BITS-1:0]   wr_data,
  output logic [2:0]              rd_sel,
  output logic [CHAN_FIELD_W-1:0] rd_ch,
  input  logic [SETUP_BITS-1:0]   rd_data,
  output logic                    sdo,
  output phase_e                  phase,
  output logic [CNT_W-1:0]        bit_cnt
);
  logic [SETUP_BITS-1:0] in_sh, out_sh, shifted;
  logic [15:0]           win, win_next;
  cmd_t                  cmd_q, byte_now;
  logic [CNT_W-1:0]      cnt_q, last_q;
  phase_e                ph_q;
  logic                  sdo_q, sync_hit;

  function automatic logic cmd_ok(cmd_t c);
    logic chan_in_range;
    chan_in_range = 32'(c.chan) < NUM_CH;
    if (c.conv) return 1'b0;
    case (c.sel)
      SEL_CONFIG, SEL_SETUP: return 1'b1;
      SEL_OFFSET, SEL_GAIN:  return chan_in_range;
      default:               return 1'b0;
    endcase
  endfunction

  assign shifted  = {in_sh[SETUP_BITS-2:0], sdi};
  assign byte_now = cmd_t'(shifted[7:0]);
  assign win_next = {win[14:0], sdi};
  assign sync_hit = rise && (win_next == RESYNC_PAIR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_CMD;
      cnt_q  <= '0;
      last_q <= '0;
      win    <= '0;
      in_sh  <= '0;
      out_sh <= '0;
      cmd_q  <= '0;
      sdo_q  <= 1'b0;
    end else if (cs_n) begin
      ph_q  <= PH_CMD;
      cnt_q <= '0;
      win   <= '0;
      sdo_q <= 1'b0;
    end else begin
      if (rise) begin
        win   <= win_next;
        in_sh <= shifted;
        if (sync_hit) begin
          ph_q  <= PH_CMD;
          cnt_q <= '0;
        end else if (ph_q == PH_CMD) begin
          if (cnt_q == CNT_W'(7)) begin
            cnt_q <= '0;
            if (cmd_ok(byte_now)) begin
              cmd_q  <= byte_now;
              last_q <= (byte_now.sel == SEL_SETUP) ? CNT_W'(SETUP_BITS-1)
                                                    : CNT_W'(WORD_W-1);
              if (byte_now.rd) begin
                ph_q   <= PH_RD;
                out_sh <= rd_data;
              end else begin
                ph_q <= PH_WR;
              end
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else if (cnt_q == last_q) begin
          ph_q  <= PH_CMD;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (fall) begin
        if (ph_q == PH_RD) begin
          sdo_q  <= out_sh[SETUP_BITS-1];
          out_sh <= out_sh << 1;
        end else begin
          sdo_q <= 1'b0;
        end
      end
    end
  end

  assign wr_en   = rise && !cs_n && !sync_hit && (ph_q == PH_WR) && (cnt_q == last_q);
  assign wr_sel  = cmd_q.sel;
  assign wr_ch   = cmd_q.chan;
  assign wr_data = shifted;
  assign rd_sel  = byte_now.sel;
  assign rd_ch   = byte_now.chan;
  assign sdo     = sdo_q;
  assign phase   = ph_q;
  assign bit_cnt = cnt_q;
endmodule

// File: rtl/adc_cmd_port.sv
module adc_cmd_port
  import adc_port_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int WORD_W    = 24,
  parameter int SETUP_W   = 12,
  parameter int NUM_SETUP = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdo_oe
);
  localparam int SETUP_BITS = SETUP_W * NUM_SETUP;
  localparam int CNT_W      = $clog2(SETUP_BITS);

  logic                    sclk_rise, sclk_fall;
  logic                    wr_en;
  logic [2:0]              wr_sel, rd_sel;
  logic [CHAN_FIELD_W-1:0] wr_ch, rd_ch;
  logic [SETUP_BITS-1:0]   wr_data, rd_data;
  phase_e                  phase;
  logic [CNT_W-1:0]        bit_cnt;

  adc_port_edge u_edge (
    .clk (clk), .rst_n (rst_n), .sclk (sclk),
    .rise (sclk_rise), .fall (sclk_fall)
  );

  adc_port_ctrl #(
    .NUM_CH (NUM_CH), .WORD_W (WORD_W), .SETUP_BITS (SETUP_BITS), .CNT_W (CNT_W)
  ) u_ctrl (
    .clk (clk), .rst_n (rst_n), .cs_n (cs_n),
    .rise (sclk_rise), .fall (sclk_fall), .sdi (sdi),
    .wr_en (wr_en), .wr_sel (wr_sel), .wr_ch (wr_ch), .wr_data (wr_data),
    .rd_sel (rd_sel), .rd_ch (rd_ch), .rd_data (rd_data),
    .sdo (sdo), .phase (phase), .bit_cnt (bit_cnt)
  );

  adc_port_regs #(
    .NUM_CH (NUM_CH), .WORD_W (WORD_W), .SETUP_BITS (SETUP_BITS)
  ) u_regs (
    .clk (clk), .rst_n (rst_n),
    .wr_en (wr_en), .wr_sel (wr_sel), .wr_ch (wr_ch), .wr_data (wr_data),
    .rd_sel (rd_sel), .rd_ch (rd_ch), .rd_data (rd_data)
  );

  assign sdo_oe = ~cs_n;
endmodule

// File: rtl/adc_cmd_port_chk.sv
module adc_cmd_port_chk
  import adc_port_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 7
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cs_n,
  input logic                    sdo,
  input logic                    sclk_fall,
  input logic                    wr_en,
  input logic [2:0]              wr_sel,
  input logic [CHAN_FIELD_W-1:0] wr_ch,
  input phase_e                  phase,
  input logic [CNT_W-1:0]        bit_cnt
);
  // R6: a deselected port drives SDO low
  a_r6_sdo_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (sdo == 1'b0));

  // R3: SDO moves only after a falling SCLK edge while selected
  a_r3_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && !$stable(sdo)) |-> $past(sclk_fall));

  // R4: storage is only written through a legal select code
  a_r4_write_legal_sel: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_sel == SEL_OFFSET || wr_sel == SEL_GAIN ||
               wr_sel == SEL_CONFIG || wr_sel == SEL_SETUP));

  // R5: per-channel writes stay within the stored channels
  a_r5_write_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_sel == SEL_OFFSET || wr_sel == SEL_GAIN)) |-> (32'(wr_ch) < NUM_CH));

  // R7: deselection returns the framing to the start of a command byte
  a_r7_abort_reframe: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (phase == PH_CMD && bit_cnt == '0));
endmodule

bind adc_cmd_port adc_cmd_port_chk #(.NUM_CH (NUM_CH), .CNT_W (CNT_W)) u_chk (
  .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sdo (sdo), .sclk_fall (sclk_fall),
  .wr_en (wr_en), .wr_sel (wr_sel), .wr_ch (wr_ch),
  .phase (phase), .bit_cnt (bit_cnt)
);

// File: tb/adc_cmd_port_bench.sv
module adc_cmd_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sdo, sdo_oe;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [95:0] d;
    int          n;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  logic        rd_active = 1'b0;
  logic [95:0] acc = '0;
  int          nb = 0;

  always #4 clk = ~clk;

  adc_cmd_port u_adc_cmd_port (
    .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sclk (sclk),
    .sdi (sdi), .sdo (sdo), .sdo_oe (sdo_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: assemble SDO bits on rising SCLK and compare against the scoreboard
  always @(posedge sclk) begin
    if (rd_active) begin
      acc = {acc[94:0], sdo};
      nb++;
      if (exp_q.size() > 0 && nb == exp_q[0].n) begin
        exp_t it;
        it = exp_q.pop_front();
        chk(acc == it.d, it.tag, acc, it.d);
        acc = '0;
        nb = 0;
      end
    end
  end

  function automatic logic [7:0] mk_cmd(input bit rd, input logic [2:0] sel, input logic [2:0] ch);
    return {1'b0, ch, rd, sel};
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk) sdi = b;
    repeat (3) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic send_bits(input logic [95:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic select();
    @(negedge clk) cs_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic deselect();
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  // driver: queue the expected word, then clock the read out
  task automatic read_body(input logic [7:0] cmd, input logic [95:0] exp, input int n, input string tag);
    exp_q.push_back('{d: exp, n: n, tag: tag});
    send_bits({88'h0, cmd}, 8);
    rd_active = 1'b1;
    send_bits('0, n);
    rd_active = 1'b0;
  endtask

  task automatic read_reg(input logic [7:0] cmd, input logic [95:0] exp, input int n, input string tag);
    select();
    read_body(cmd, exp, n, tag);
    deselect();
  endtask

  task automatic write_reg(input logic [7:0] cmd, input logic [95:0] data, input int n);
    select();
    send_bits({88'h0, cmd}, 8);
    send_bits(data, n);
    deselect();
  endtask

  localparam logic [95:0] SETUP_PAT = 96'h1357_9BDF_2468_ACE0_0F1E_2D3C;

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    chk(sdo_oe == 1'b0 && sdo == 1'b0, "R6 idle after reset", {94'h0, sdo_oe, sdo}, '0);

    // reset values
    read_reg(mk_cmd(1, 3'b011, 3'd0), 96'h0,      24, "R2 config reset");
    read_reg(mk_cmd(1, 3'b010, 3'd0), 96'h400000, 24, "R2 gain ch0 reset");
    read_reg(mk_cmd(1, 3'b001, 3'd2), 96'h0,      24, "R2 offset ch2 reset");
    read_reg(mk_cmd(1, 3'b101, 3'd0), 96'h0,      96, "R2 R8 setup chain reset");

    // write and readback, MSB-first timing R3
    write_reg(mk_cmd(0, 3'b011, 3'd0), 96'hA5C31E, 24);
    read_reg(mk_cmd(1, 3'b011, 3'd0), 96'hA5C31E, 24, "R10 R3 config readback");
    write_reg(mk_cmd(0, 3'b001, 3'd1), 96'h123456, 24);
    write_reg(mk_cmd(0, 3'b010, 3'd3), 96'h00FF0F, 24);
    read_reg(mk_cmd(1, 3'b001, 3'd1), 96'h123456, 24, "R5 R1 offset ch1");
    read_reg(mk_cmd(1, 3'b001, 3'd0), 96'h0,      24, "R5 offset ch0 untouched");
    read_reg(mk_cmd(1, 3'b010, 3'd3), 96'h00FF0F, 24, "R5 gain ch3");
    read_reg(mk_cmd(1, 3'b011, 3'd6), 96'hA5C31E, 24, "R5 config disregards channel");

    // out-of-range channel and reserved codes are single ignored bytes
    select();
    chk(sdo_oe == 1'b1, "R6 enable while selected", {95'h0, sdo_oe}, 96'h1);
    send_bits({88'h0, mk_cmd(0, 3'b001, 3'd5)}, 8);
    read_body(mk_cmd(1, 3'b001, 3'd1), 96'h123456, 24, "R5 channel 5 ignored");
    send_bits({88'h0, mk_cmd(0, 3'b110, 3'd0)}, 8);
    send_bits({88'h0, 8'h00}, 8);
    send_bits({88'h0, 8'h80 | mk_cmd(0, 3'b011, 3'd0)}, 8);
    read_body(mk_cmd(1, 3'b011, 3'd0), 96'hA5C31E, 24, "R4 reserved null conv ignored");
    deselect();
    chk(sdo_oe == 1'b0 && sdo == 1'b0, "R6 idle after transfer", {94'h0, sdo_oe, sdo}, '0);

    // setup chain
    write_reg(mk_cmd(0, 3'b101, 3'd0), SETUP_PAT, 96);
    read_reg(mk_cmd(1, 3'b101, 3'd0), SETUP_PAT, 96, "R8 setup chain readback");

    // aborts
    select();
    send_bits({88'h0, mk_cmd(0, 3'b011, 3'd0)}, 8);
    send_bits(96'h3FF, 10);
    deselect();
    read_reg(mk_cmd(1, 3'b011, 3'd0), 96'hA5C31E, 24, "R7 config abort keeps value");
    select();
    send_bits({88'h0, mk_cmd(0, 3'b101, 3'd0)}, 8);
    send_bits(96'h0, 72);
    deselect();
    read_reg(mk_cmd(1, 3'b101, 3'd0), SETUP_PAT, 96, "R8 R7 partial chain not committed");

    // resync inside write payload
    select();
    send_bits({88'h0, mk_cmd(0, 3'b011, 3'd0)}, 8);
    send_bits(96'h0A, 5);
    send_bits(96'hFFFE, 16);
    read_body(mk_cmd(1, 3'b011, 3'd0), 96'hA5C31E, 24, "R9 resync discards write");
    // misaligned resync during command phase
    send_bits(96'h5, 3);
    send_bits(96'hFFFE, 16);
    read_body(mk_cmd(1, 3'b010, 3'd3), 96'h00FF0F, 24, "R9 misaligned resync reframes");
    deselect();

    chk(exp_q.size() == 0, "R3 all queued reads observed", 96'(exp_q.size()), '0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired R1 actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule